// File: doc/BRIEF.md
# SPI Secondary Command Protocol Engine

This block is the device side of a mode-0 SPI link (clock idles low, data sampled on the rising clock edge, changed on the falling edge). It decodes a byte-oriented command protocol from the host and answers on MISO with status bytes, a start marker and read data. The SPI pins are sampled with the block's own system clock through a short synchronizer, so every internal output is synchronous to `clk`.

The link must first be unlocked by a three-byte magic sequence followed by one dummy byte, during which the status is returned. After that, each transaction opens with two command bytes. The first gives the kind of access, its direction, its target (register, memory or frame) and its length form. The second gives the data granularity (8-bit or 32-bit) and, for register access, a 6-bit register address. Two length bytes and a four-byte memory address follow only when the command calls for them. Once the header is complete, the engine pulses a decoded transaction to the device core. Write data is then handed over one unit at a time. For reads, the engine sends filler until the core flags data as ready, then a start marker, then the requested data.

Top module: `spi_cmd_engine`

## Requirements
- R1: MOSI is sampled on rising SCLK edges and MISO changes only after falling SCLK edges. Every byte and 32-bit word is sent MSB first. MISO stays 0 whenever no status, marker or data is defined.
- R2: Before unlock, the byte sequence 0x12, 0x4A, 0x5C plus one dummy byte unlocks the link and returns 0x58 during the dummy byte. If `dev_busy` is high when 0x5C completes, 0x54 is returned instead and the link stays locked.
- R3: While locked, any other byte sequence, including a wrong magic sequence, gives MISO 0 and produces no transaction, write or read take.
- R4: A magic sequence sent after a successful unlock returns 0x52 during its dummy byte.
- R5: The first command byte carries the type in [7:6] (01 read/write, 1x reserved), write=1 in [5], memory-or-frame=1 in [4], frame=1 in [3], 16-bit length=1 in [2] and the short length in [1:0]. The second byte carries the granularity in [7:6] (00 8-bit, 01 32-bit, 1x reserved) and the register address in [5:0]. The status goes out during the unit after the second byte, in that unit's top 8 bits: 0x58 when accepted, 0x52 for a reserved type or granularity, and 0x54 when `dev_busy` is high (only if there is no failure). A refused command gives no transaction.
- R6: The short length code maps 01/10/11/00 to 1/2/3/4 bytes. When bit [2] is set on a memory or frame access, two length bytes follow, low byte first. Register access skips both length bytes and the address, and uses the short code.
- R7: A memory access has four address bytes after the length bytes, least significant byte first. A frame access has none. `txn_valid` pulses for one cycle once the header is complete.
- R8: Each received data unit gives one `wr_valid` pulse. An 8-bit unit is zero-extended, and a 32-bit unit is presented as received MSB first. Units beyond the transfer length are ignored.
- R9: A read returns 0 per unit while `rd_ready` is low. It then sends the start marker (0x55, or word 0x00000055 in 32-bit mode), followed by one unit of `rd_data` per `rd_take` pulse until the length is covered, and then 0.
- R10: Raising CS aborts the transaction and restarts byte framing. The unlock state is kept.
- R11: After reset, MISO is 0, the link is locked and no pulse outputs are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to host |
| txn_valid | output | 1 | One-cycle pulse: decoded header ready |
| txn_write | output | 1 | Transaction is a write |
| txn_mem | output | 1 | Memory or frame access (0 = register) |
| txn_frame | output | 1 | Frame access |
| txn_wide | output | 1 | 32-bit data granularity |
| txn_reg_addr | output | 6 | Register address |
| txn_len | output | 16 | Transfer length in bytes |
| txn_addr | output | 32 | Memory address |
| wr_valid | output | 1 | One-cycle pulse: write unit available |
| wr_data | output | 32 | Write unit |
| rd_data | input | 32 | Read unit from core |
| rd_ready | input | 1 | Core has read data |
| rd_take | output | 1 | One-cycle pulse: read unit consumed |
| dev_busy | input | 1 | Previous transaction still pending |

## Verification
Directed host transfers cover several patterns. The unlock is tried with a wrong magic byte, with the core busy, correctly, and a second time. Together these separate the 0x58, 0x54 and 0x52 answers and show that locked traffic is silent. Register, memory and frame accesses are then sent in both granularities, with short and 16-bit lengths. Each one shows whether the length and address bytes are consumed or skipped, whether multi-byte fields are assembled low byte first, and whether the status lands in the top byte of a 32-bit unit. Reads run with the data delayed and with it ready at once, which separates filler from the start marker. CS aborts in the middle of a byte and between bytes show that framing restarts while the unlock state is kept.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int BYTE_BITS = 8;
    localparam int WORD_BITS = 32;
    localparam int LEN_BITS  = 16;

    localparam logic [7:0] MAGIC_A   = 8'h12;
    localparam logic [7:0] MAGIC_B   = 8'h4A;
    localparam logic [7:0] MAGIC_C   = 8'h5C;
    localparam logic [7:0] RSP_OK    = 8'h58;
    localparam logic [7:0] RSP_BUSY  = 8'h54;
    localparam logic [7:0] RSP_FAIL  = 8'h52;
    localparam logic [7:0] RSP_START = 8'h55;

    typedef enum logic [3:0] {
        PH_CMD1, PH_MAGIC, PH_DUMMY, PH_CMD2, PH_LEN,
        PH_ADDR, PH_WDATA, PH_RWAIT, PH_RDATA, PH_DRAIN
    } phase_t;

    function automatic logic [LEN_BITS-1:0] short_len(input logic [1:0] code);
        return (code == 2'b00) ? LEN_BITS'(4) : LEN_BITS'(code);
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic cs_n_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_act
);
    localparam int LAST = STAGES - 1;

    logic [2:0] stage_q [STAGES];
    logic       sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= 3'b100;
            sclk_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= {cs_n_i, mosi_i, sclk_i};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            sclk_prev_q <= stage_q[LAST][0];
        end
    end

    assign cs_act    = ~stage_q[LAST][2];
    assign mosi_s    = stage_q[LAST][1];
    assign sclk_rise = stage_q[LAST][0] & ~sclk_prev_q;
    assign sclk_fall = ~stage_q[LAST][0] & sclk_prev_q;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
    import spi_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_act,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 mosi_s,
    input  logic                 wide_unit,
    input  logic [WORD_BITS-1:0] load_val,
    output logic                 unit_done,
    output logic [WORD_BITS-1:0] unit_val,
    output logic                 miso
);
    localparam int CNT_W = $clog2(WORD_BITS);

    typedef struct packed {
        logic [WORD_BITS-1:0] rx;
        logic [WORD_BITS-1:0] tx;
        logic [CNT_W-1:0]     cnt;
        logic                 pend;
        logic [WORD_BITS-1:0] pval;
    } shift_t;

    shift_t q, d;
    logic [CNT_W-1:0] last_bit;

    assign last_bit  = wide_unit ? CNT_W'(WORD_BITS-1) : CNT_W'(BYTE_BITS-1);
    assign unit_val  = {q.rx[WORD_BITS-2:0], mosi_s};
    assign unit_done = cs_act & sclk_rise & (q.cnt == last_bit);
    assign miso      = cs_act & q.tx[WORD_BITS-1];

    always_comb begin
        d = q;
        if (!cs_act) begin
            d = '0;
        end else begin
            if (sclk_rise) begin
                d.rx = unit_val;
                if (q.cnt == last_bit) begin
                    d.cnt  = '0;
                    d.pend = 1'b1;
                    d.pval = load_val;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            if (sclk_fall) begin
                if (q.pend) begin
                    d.tx   = q.pval;
                    d.pend = 1'b0;
                end else begin
                    d.tx = q.tx << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_mosi,
    input  logic                 spi_cs_n,
    output logic                 spi_miso,
    output logic                 txn_valid,
    output logic                 txn_write,
    output logic                 txn_mem,
    output logic                 txn_frame,
    output logic                 txn_wide,
    output logic [5:0]           txn_reg_addr,
    output logic [LEN_BITS-1:0]  txn_len,
    output logic [WORD_BITS-1:0] txn_addr,
    output logic                 wr_valid,
    output logic [WORD_BITS-1:0] wr_data,
    input  logic [WORD_BITS-1:0] rd_data,
    input  logic                 rd_ready,
    output logic                 rd_take,
    input  logic                 dev_busy
);
    localparam int REM_W = LEN_BITS + 1;

    typedef struct packed {
        phase_t               ph;
        logic [1:0]           cnt;
        logic                 unlocked;
        logic [7:0]           c1;
        logic                 wide;
        logic [5:0]           reg_addr;
        logic [LEN_BITS-1:0]  len;
        logic [WORD_BITS-1:0] addr;
        logic [REM_W-1:0]     rem;
        logic                 txn_v;
        logic                 wr_v;
        logic [WORD_BITS-1:0] wr_d;
        logic                 take;
    } eng_t;

    eng_t q, d;

    logic sclk_rise, sclk_fall, mosi_s, cs_act;
    logic unit_done, wide_unit, hdr_done, stat_now;
    logic [WORD_BITS-1:0] unit_val, load_val;
    logic [7:0] b;
    logic [REM_W-1:0] ub;
    logic init_flag;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .mosi_i(spi_mosi),
        .cs_n_i(spi_cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_s(mosi_s), .cs_act(cs_act)
    );

    spi_bit_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .mosi_s(mosi_s), .wide_unit(wide_unit),
        .load_val(load_val), .unit_done(unit_done), .unit_val(unit_val),
        .miso(spi_miso)
    );

    assign wide_unit = q.wide && (q.ph inside {PH_WDATA, PH_RWAIT, PH_RDATA});
    assign b         = unit_val[7:0];
    assign ub        = q.wide ? REM_W'(4) : REM_W'(1);

    // Next-state logic: all decisions happen on the rising edge that ends a unit
    always_comb begin
        d        = q;
        d.txn_v  = 1'b0;
        d.wr_v   = 1'b0;
        d.take   = 1'b0;
        load_val = '0;
        hdr_done = 1'b0;
        stat_now = 1'b0;
        if (!cs_act) begin
            d.ph  = PH_CMD1;
            d.cnt = '0;
        end else if (unit_done) begin
            unique case (q.ph)
                PH_CMD1: begin
                    d.c1  = b;
                    d.cnt = '0;
                    if (b == MAGIC_A)
                        d.ph = PH_MAGIC;
                    else if (q.unlocked && b[7:6] != 2'b00)
                        d.ph = PH_CMD2;
                    else
                        d.ph = PH_DRAIN;
                end
                PH_MAGIC: begin
                    if (q.cnt == 2'd0 && b == MAGIC_B) begin
                        d.cnt = 2'd1;
                    end else if (q.cnt == 2'd1 && b == MAGIC_C) begin
                        d.ph = PH_DUMMY;
                        if (q.unlocked) begin
                            load_val[31:24] = RSP_FAIL;
                        end else if (dev_busy) begin
                            load_val[31:24] = RSP_BUSY;
                        end else begin
                            load_val[31:24] = RSP_OK;
                            d.unlocked      = 1'b1;
                        end
                    end else begin
                        d.ph = PH_DRAIN;
                    end
                end
                PH_CMD2: begin
                    stat_now = 1'b1;
                    if (q.c1[7] || b[7]) begin
                        load_val[31:24] = RSP_FAIL;
                        d.ph            = PH_DRAIN;
                    end else if (dev_busy) begin
                        load_val[31:24] = RSP_BUSY;
                        d.ph            = PH_DRAIN;
                    end else begin
                        load_val[31:24] = RSP_OK;
                        d.wide          = b[6];
                        d.reg_addr      = b[5:0];
                        d.len           = short_len(q.c1[1:0]);
                        d.cnt           = '0;
                        if (!q.c1[4])     hdr_done = 1'b1;
                        else if (q.c1[2]) d.ph = PH_LEN;
                        else if (!q.c1[3]) d.ph = PH_ADDR;
                        else              hdr_done = 1'b1;
                    end
                end
                PH_LEN: begin
                    if (q.cnt == 2'd0) begin
                        d.len[7:0] = b;
                        d.cnt      = 2'd1;
                    end else begin
                        d.len[15:8] = b;
                        d.cnt       = '0;
                        if (!q.c1[3]) d.ph = PH_ADDR;
                        else          hdr_done = 1'b1;
                    end
                end
                PH_ADDR: begin
                    d.addr = {b, q.addr[WORD_BITS-1:8]};
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == 2'd3) hdr_done = 1'b1;
                end
                PH_WDATA: begin
                    d.wr_v = 1'b1;
                    d.wr_d = q.wide ? unit_val : {24'h0, b};
                    if (q.rem <= ub) begin
                        d.rem = '0;
                        d.ph  = PH_DRAIN;
                    end else begin
                        d.rem = q.rem - ub;
                    end
                end
                PH_RWAIT: begin
                    if (rd_ready) begin
                        load_val = q.wide ? 32'h55 : {RSP_START, 24'h0};
                        d.ph     = PH_RDATA;
                    end
                end
                PH_RDATA: begin
                    if (q.rem == '0) begin
                        d.ph = PH_DRAIN;
                    end else begin
                        load_val = q.wide ? rd_data : {rd_data[7:0], 24'h0};
                        d.take   = 1'b1;
                        d.rem    = (q.rem > ub) ? q.rem - ub : '0;
                    end
                end
                default: d.ph = PH_DRAIN;
            endcase

            if (hdr_done) begin
                d.txn_v = 1'b1;
                d.rem   = {1'b0, d.len};
                if (q.c1[5]) begin
                    d.ph = (d.len == '0) ? PH_DRAIN : PH_WDATA;
                end else begin
                    d.ph = PH_RWAIT;
                    if (!stat_now && rd_ready) begin
                        load_val = d.wide ? 32'h55 : {RSP_START, 24'h0};
                        d.ph     = PH_RDATA;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_CMD1;
        end else begin
            q <= d;
        end
    end

    assign init_flag    = q.unlocked;
    assign txn_valid    = q.txn_v;
    assign txn_write    = q.c1[5];
    assign txn_mem      = q.c1[4];
    assign txn_frame    = q.c1[3];
    assign txn_wide     = q.wide;
    assign txn_reg_addr = q.reg_addr;
    assign txn_len      = q.len;
    assign txn_addr     = q.addr;
    assign wr_valid     = q.wr_v;
    assign wr_data      = q.wr_d;
    assign rd_take      = q.take;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic txn_valid,
    input logic wr_valid,
    input logic rd_take,
    input logic init_flag
);
    // R3: no transaction is decoded while the link is locked
    p_txn_needs_unlock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> init_flag);

    // R10: once unlocked, the link stays unlocked until reset
    p_unlock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_flag |=> init_flag);

    // R7: the header pulse lasts one cycle
    p_txn_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !txn_valid);

    // R8 / R9: a transaction never writes and takes read data at once
    p_wr_take_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_take));

    // R1: MISO is quiet while chip select has stayed high
    p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk i_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .txn_valid(txn_valid), .wr_valid(wr_valid), .rd_take(rd_take),
    .init_flag(init_flag)
);

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic miso;
    logic txn_valid, txn_write, txn_mem, txn_frame, txn_wide;
    logic [5:0] txn_reg_addr;
    logic [15:0] txn_len;
    logic [31:0] txn_addr;
    logic wr_valid, rd_take;
    logic [31:0] wr_data, rd_data;
    logic rd_ready = 1'b0, dev_busy = 1'b0;

    int n_chk = 0, n_fail = 0, unstable = 0;
    int txn_cnt = 0, wr_cnt = 0, take_cnt = 0;
    logic [31:0] wr_buf [16];
    logic c_write, c_mem, c_frame, c_wide;
    logic [5:0] c_reg;
    logic [15:0] c_len;
    logic [31:0] c_addr;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_cmd_engine i_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_cs_n(cs_n), .spi_miso(miso), .txn_valid(txn_valid),
        .txn_write(txn_write), .txn_mem(txn_mem), .txn_frame(txn_frame),
        .txn_wide(txn_wide), .txn_reg_addr(txn_reg_addr), .txn_len(txn_len),
        .txn_addr(txn_addr), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_data(rd_data), .rd_ready(rd_ready), .rd_take(rd_take),
        .dev_busy(dev_busy)
    );

    function automatic logic [31:0] rd_word(input int k);
        return 32'hA0B0C0D0 + 32'(k) * 32'h01010101;
    endfunction
    assign rd_data = rd_word(take_cnt);

    // Core-side model: records what the engine hands over
    always @(posedge clk) begin
        if (txn_valid) begin
            txn_cnt <= txn_cnt + 1;
            c_write <= txn_write; c_mem <= txn_mem; c_frame <= txn_frame;
            c_wide <= txn_wide; c_reg <= txn_reg_addr; c_len <= txn_len;
            c_addr <= txn_addr;
        end
        if (wr_valid) begin
            wr_buf[wr_cnt % 16] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (rd_take) take_cnt <= take_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input int nbits, input logic [31:0] o, output logic [31:0] r);
        logic s;
        r = '0;
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = o[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            s = miso;
            r[i] = s;
            repeat (HALF) @(negedge clk);
            if (miso !== s) unstable++;
            sclk = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] o, output logic [7:0] r);
        logic [31:0] t;
        xfer(8, {24'h0, o}, t);
        r = t[7:0];
    endtask

    task automatic cs_on();
        @(negedge clk); cs_n = 1'b0; repeat (HALF) @(negedge clk);
    endtask
    task automatic cs_off();
        repeat (HALF) @(negedge clk); cs_n = 1'b1; repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 miso after reset", miso, 0);
        chk("R11 no txn after reset", txn_cnt, 0);
    endtask

    task automatic t_locked();
        logic [7:0] r0, r1, r2, r3;
        int t0 = txn_cnt;
        cs_on(); xb(8'h41, r0); xb(8'h05, r1); xb(8'h00, r2); cs_off();
        chk("R3 locked command silent", {r0, r1, r2}, 0);
        cs_on(); xb(8'h12, r0); xb(8'h4B, r1); xb(8'h5C, r2); xb(8'h00, r3); cs_off();
        chk("R3 wrong magic silent", {r0, r1, r2, r3}, 0);
        chk("R3 no txn while locked", txn_cnt - t0, 0);
    endtask

    task automatic t_magic(input logic busy, input logic [7:0] exp, input string tag);
        logic [7:0] r0, r1, r2, r3;
        dev_busy = busy;
        cs_on(); xb(8'h12, r0); xb(8'h4A, r1); xb(8'h5C, r2); xb(8'h00, r3); cs_off();
        dev_busy = 1'b0;
        chk({tag, " magic bytes echo 0"}, {r0, r1, r2}, 0);
        chk({tag, " dummy-byte status"}, r3, exp);
    endtask

    task automatic t_still_locked();
        logic [7:0] r0, r1, r2;
        int t0 = txn_cnt;
        cs_on(); xb(8'h41, r0); xb(8'h05, r1); xb(8'h00, r2); cs_off();
        chk("R2 busy unlock keeps link locked", {r2, 8'(txn_cnt - t0)}, 0);
    endtask

    task automatic t_reg_read();
        logic [7:0] r0, r1, rs, rf, rt, rd, rz;
        int t0 = txn_cnt, k0 = take_cnt;
        rd_ready = 1'b0;
        cs_on(); xb(8'h41, r0); xb(8'h05, r1); xb(8'h00, rs);
        rd_ready = 1'b1;
        xb(8'h00, rf); xb(8'h00, rt); xb(8'h00, rd); xb(8'h00, rz); cs_off();
        rd_ready = 1'b0;
        chk("R5 register read status", rs, 8'h58);
        chk("R9 filler while not ready", rf, 0);
        chk("R9 start marker", rt, 8'h55);
        chk("R9 read data byte", rd, rd_word(k0) & 32'hFF);
        chk("R9 filler after length", rz, 0);
        chk("R9 one take", take_cnt - k0, 1);
        chk("R6 register txn fields", {8'(txn_cnt - t0), 1'(c_write), 1'(c_mem), 1'(c_wide), c_reg, c_len},
            {8'd1, 1'b0, 1'b0, 1'b0, 6'd5, 16'd1});
    endtask

    task automatic t_mem_write();
        logic [7:0] r [11];
        int w0 = wr_cnt, t0 = txn_cnt;
        logic [7:0] o [11] = '{8'h74, 8'h00, 8'h02, 8'h00, 8'h78, 8'h56, 8'h34, 8'h12, 8'hA1, 8'hB2, 8'hCC};
        cs_on();
        for (int i = 0; i < 11; i++) xb(o[i], r[i]);
        cs_off();
        chk("R5 status during first length byte", {r[0], r[1], r[2], r[3]}, {24'h0, 8'h58} << 8);
        chk("R7 memory address low byte first", c_addr, 32'h12345678);
        chk("R6 16-bit length", c_len, 16'd2);
        chk("R7 memory write fields", {8'(txn_cnt - t0), 1'(c_write), 1'(c_mem), 1'(c_frame)}, {8'd1, 3'b110});
        chk("R8 write count bounded by length", wr_cnt - w0, 2);
        chk("R8 write data", {wr_buf[w0 % 16][15:0], wr_buf[(w0 + 1) % 16][15:0]}, 32'h00A100B2);
    endtask

    task automatic t_frame_write32();
        logic [7:0] r0, r1;
        logic [31:0] rw, rx;
        int w0 = wr_cnt;
        cs_on(); xb(8'h78, r0); xb(8'h40, r1);
        xfer(32, 32'hDEADBEEF, rw); xfer(32, 32'h12345678, rx); cs_off();
        chk("R5 status in top byte of wide unit", rw, 32'h58000000);
        chk("R8 wide write word", wr_buf[w0 % 16], 32'hDEADBEEF);
        chk("R8 excess wide unit ignored", wr_cnt - w0, 1);
        chk("R6 short code 00 is 4 bytes, frame, wide", {c_len, 1'(c_frame), 1'(c_wide)}, {16'd4, 2'b11});
    endtask

    task automatic t_frame_read32();
        logic [7:0] r0, r1, r2, r3;
        logic [31:0] wt, w1, w2, wz;
        int k0 = take_cnt;
        rd_ready = 1'b1;
        cs_on(); xb(8'h5C, r0); xb(8'h40, r1); xb(8'h08, r2); xb(8'h00, r3);
        xfer(32, 0, wt); xfer(32, 0, w1); xfer(32, 0, w2); xfer(32, 0, wz); cs_off();
        rd_ready = 1'b0;
        chk("R5 frame read status", r2, 8'h58);
        chk("R9 wide start marker", wt, 32'h00000055);
        chk("R9 wide read words", {w1 ^ rd_word(k0)} | {w2 ^ rd_word(k0 + 1)}, 0);
        chk("R9 wide filler after length", wz, 0);
        chk("R7 frame read has no address phase", {c_len, 1'(c_mem), 1'(c_frame), 1'(c_write)}, {16'd8, 3'b110});
    endtask

    task automatic t_refused();
        logic [7:0] r0, r1, r2, r3;
        int t0 = txn_cnt;
        dev_busy = 1'b1;
        cs_on(); xb(8'h41, r0); xb(8'h05, r1); xb(8'h00, r2); xb(8'h00, r3); cs_off();
        dev_busy = 1'b0;
        chk("R5 busy status", {r2, r3}, 16'h5400);
        cs_on(); xb(8'hC1, r0); xb(8'h05, r1); xb(8'h00, r2); cs_off();
        chk("R5 reserved type fails", r2, 8'h52);
        cs_on(); xb(8'h41, r0); xb(8'h80, r1); xb(8'h00, r2); cs_off();
        chk("R5 reserved granularity fails", r2, 8'h52);
        chk("R5 refused commands give no txn", txn_cnt - t0, 0);
    endtask

    task automatic t_abort();
        logic [7:0] r0, r1, r2;
        logic [31:0] t;
        int w0 = wr_cnt;
        cs_on(); xb(8'h61, r0); xb(8'h07, r1); cs_off();
        cs_on(); xfer(5, 32'h1F, t); cs_off();
        cs_on(); xb(8'h61, r0); xb(8'h07, r1); xb(8'h3C, r2); cs_off();
        chk("R10 unlock kept after abort", r2, 8'h58);
        chk("R10 framing restarts, one write", wr_cnt - w0, 1);
        chk("R10 write after abort", wr_buf[w0 % 16], 32'h3C);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_locked();
        t_magic(1'b1, 8'h54, "R2 busy unlock");
        t_still_locked();
        t_magic(1'b0, 8'h58, "R2 unlock");
        t_magic(1'b0, 8'h52, "R4 second unlock");
        t_reg_read();
        t_mem_write();
        t_frame_write32();
        t_frame_read32();
        t_refused();
        t_abort();
        chk("R1 miso stable while sclk high", unstable, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule